// File: doc/BRIEF.md
# Pin Controller with Level-Match Interrupts

This block is a memory-mapped controller for fourteen general-purpose pins, reached over a simple 32-bit word bus with a registered read path. For each pin, software picks between plain software-driven I/O and a fixed alternate peripheral signal. In software mode, a direction bit decides whether the pin drives, and a data bit gives the driven value. In alternate mode, the peripheral supplies the driven value, and each pin has a fixed direction that overrides the direction bit.

Every pin input passes through a two-flop synchronizer. The synchronized value is used in three places: it is returned on data reads, it is handed to the alternate peripherals, and it is compared each cycle against a per-pin programmed level. Whenever a pin equals its level, the pin's status bit is set. A status bit stays set until software writes a 1 to it. A per-pin enable selects which status bits feed a single registered non-maskable interrupt line.

Top module: `gpio_lvl_ctrl`

## Requirements
- R1: After reset, every register is zero, so that every pin is a software-mode input: pin_oe is 0, pin_out is 0 and nmi_o is 0.
- R2: The bus_addr word index selects the register: 0 is function select, 1 is direction, 2 is data, 3 is match level, 4 is status and 5 is interrupt enable. Read data appears on bus_rdata at the negedge after the read cycle's clock edge, and it holds until the next read. Indices 6 and 7 read as zero.
- R3: When a function-select bit is 0, pin_oe for that pin equals its direction bit (1 means output), and pin_out equals its written data bit.
- R4: When a function-select bit is 1, pin_out for that pin equals alt_out, and pin_oe is fixed whatever the direction bit holds. Pins 0, 2, 4, 5, 6, 7, 8, 10, 12 and 13 drive, and pins 1, 3, 9 and 11 do not (mask 14'h35F5).
- R5: A read of the data register returns pin_in as it was two clock edges before the read's edge, that is, after the two-flop synchronizer.
- R6: A status bit sets one edge after its synchronized pin equals its level bit. It then stays set after the match ends.
- R7: Writing the status register clears the bits written as 1. It leaves the bits written as 0 unchanged.
- R8: If a pin still matches its level in the cycle where its status bit is written with 1, the bit stays set.
- R9: nmi_o rises one edge after any status bit whose enable bit is 1 becomes set. Set status bits that are not enabled do not raise it.
- R10: Register bits 31:14 ignore writes and read as zero.
- R11: alt_in presents each pin_in bit after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 14 | Pad input values |
| pin_out | output | 14 | Pad output values |
| pin_oe | output | 14 | Pad output enables |
| alt_out | input | 14 | Values from the alternate peripherals |
| alt_in | output | 14 | Synchronized pad values to the alternate peripherals |
| nmi_o | output | 1 | Registered non-maskable interrupt |

## Verification
A software clear and a new hardware match can fall in the same cycle on the same status bit. To provoke this, the bench holds a pin at its programmed level and writes 1 to that status bit. The bench then reads the status register back and expects the bit to still be set. Once the pin has left its level, a second clear must reach zero, which shows that the earlier result was not a dead clear path.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
    localparam int GPIO_PINS   = 14;
    localparam int GPIO_DATA_W = 32;
    localparam int GPIO_ADDR_W = 3;

    // Direction each pin takes when handed to its alternate function (1 = drive)
    localparam logic [GPIO_PINS-1:0] GPIO_ALT_DIR = 14'h35F5;

    typedef enum logic [GPIO_ADDR_W-1:0] {
        IDX_FUNC = 3'd0,
        IDX_DIR  = 3'd1,
        IDX_DATA = 3'd2,
        IDX_LVL  = 3'd3,
        IDX_STAT = 3'd4,
        IDX_NMIE = 3'd5
    } reg_idx_e;
endpackage

// File: rtl/gpio_lvl_sync.sv
module gpio_lvl_sync #(
    parameter int WIDTH  = 14,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_lvl_padmux.sv
module gpio_lvl_padmux #(
    parameter int                  NUM_PINS = 14,
    parameter logic [NUM_PINS-1:0] ALT_DIR  = '0
) (
    input  logic [NUM_PINS-1:0] func_i,
    input  logic [NUM_PINS-1:0] dir_i,
    input  logic [NUM_PINS-1:0] dout_i,
    input  logic [NUM_PINS-1:0] alt_out_i,
    output logic [NUM_PINS-1:0] pin_out_o,
    output logic [NUM_PINS-1:0] pin_oe_o
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        if (ALT_DIR[p]) begin : g_alt_drive
            assign pin_oe_o[p] = func_i[p] | dir_i[p];
        end else begin : g_alt_listen
            assign pin_oe_o[p] = ~func_i[p] & dir_i[p];
        end
        assign pin_out_o[p] = func_i[p] ? alt_out_i[p] : dout_i[p];
    end
endmodule

// File: rtl/gpio_lvl_regs.sv
module gpio_lvl_regs
    import gpio_lvl_pkg::*;
#(
    parameter int NUM_PINS = 14,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_sync,
    output logic [NUM_PINS-1:0] func_o,
    output logic [NUM_PINS-1:0] dir_o,
    output logic [NUM_PINS-1:0] dout_o,
    output logic [NUM_PINS-1:0] lvl_o,
    output logic [NUM_PINS-1:0] stat_o,
    output logic [NUM_PINS-1:0] nmie_o,
    output logic                nmi_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] func;
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] dout;
        logic [NUM_PINS-1:0] lvl;
        logic [NUM_PINS-1:0] stat;
        logic [NUM_PINS-1:0] nmie;
        logic [DATA_W-1:0]   rdata;
        logic                nmi;
    } state_t;

    state_t st_d, st_q;

    logic                wr_en, rd_en;
    logic [NUM_PINS-1:0] wbits;
    logic [NUM_PINS-1:0] match;
    logic                unused_hi;

    assign wr_en     = bus_sel & bus_wr;
    assign rd_en     = bus_sel & ~bus_wr;
    assign wbits     = bus_wdata[NUM_PINS-1:0];
    assign match     = ~(pin_sync ^ st_q.lvl);
    assign unused_hi = ^bus_wdata[DATA_W-1:NUM_PINS];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (reg_idx_e'(bus_addr))
                IDX_FUNC: st_d.func = wbits;
                IDX_DIR:  st_d.dir  = wbits;
                IDX_DATA: st_d.dout = wbits;
                IDX_LVL:  st_d.lvl  = wbits;
                IDX_STAT: st_d.stat = st_q.stat & ~wbits;
                IDX_NMIE: st_d.nmie = wbits;
                default:  ;
            endcase
        end
        // a live match overrides a clear in the same cycle
        st_d.stat = st_d.stat | match;
        st_d.nmi  = |(st_q.stat & st_q.nmie);
        if (rd_en) begin
            st_d.rdata = '0;
            case (reg_idx_e'(bus_addr))
                IDX_FUNC: st_d.rdata[NUM_PINS-1:0] = st_q.func;
                IDX_DIR:  st_d.rdata[NUM_PINS-1:0] = st_q.dir;
                IDX_DATA: st_d.rdata[NUM_PINS-1:0] = pin_sync;
                IDX_LVL:  st_d.rdata[NUM_PINS-1:0] = st_q.lvl;
                IDX_STAT: st_d.rdata[NUM_PINS-1:0] = st_q.stat;
                IDX_NMIE: st_d.rdata[NUM_PINS-1:0] = st_q.nmie;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign func_o    = st_q.func;
    assign dir_o     = st_q.dir;
    assign dout_o    = st_q.dout;
    assign lvl_o     = st_q.lvl;
    assign stat_o    = st_q.stat;
    assign nmie_o    = st_q.nmie;
    assign nmi_o     = st_q.nmi;
endmodule

// File: rtl/gpio_lvl_ctrl.sv
module gpio_lvl_ctrl
    import gpio_lvl_pkg::*;
#(
    parameter int                  NUM_PINS = GPIO_PINS,
    parameter int                  DATA_W   = GPIO_DATA_W,
    parameter int                  ADDR_W   = GPIO_ADDR_W,
    parameter int                  SYNC_LEN = 2,
    parameter logic [NUM_PINS-1:0] ALT_DIR  = GPIO_ALT_DIR
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    input  logic [NUM_PINS-1:0] alt_out,
    output logic [NUM_PINS-1:0] alt_in,
    output logic                nmi_o
);
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] func_w, dir_w, dout_w, lvl_w, stat_w, nmie_w;

    gpio_lvl_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_LEN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_sync)
    );

    gpio_lvl_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_sync  (pin_sync),
        .func_o    (func_w),
        .dir_o     (dir_w),
        .dout_o    (dout_w),
        .lvl_o     (lvl_w),
        .stat_o    (stat_w),
        .nmie_o    (nmie_w),
        .nmi_o     (nmi_o)
    );

    gpio_lvl_padmux #(.NUM_PINS(NUM_PINS), .ALT_DIR(ALT_DIR)) u_padmux (
        .func_i    (func_w),
        .dir_i     (dir_w),
        .dout_i    (dout_w),
        .alt_out_i (alt_out),
        .pin_out_o (pin_out),
        .pin_oe_o  (pin_oe)
    );

    assign alt_in = pin_sync;
endmodule

// File: rtl/gpio_lvl_chk.sv
module gpio_lvl_chk #(
    parameter int                  NUM_PINS = 14,
    parameter int                  DATA_W   = 32,
    parameter int                  ADDR_W   = 3,
    parameter logic [NUM_PINS-1:0] ALT_DIR  = '0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] func,
    input logic [NUM_PINS-1:0] dir,
    input logic [NUM_PINS-1:0] lvl,
    input logic [NUM_PINS-1:0] stat,
    input logic [NUM_PINS-1:0] nmie,
    input logic [NUM_PINS-1:0] sync,
    input logic                nmi
);
    logic stat_wr;
    assign stat_wr = bus_sel && bus_wr && (bus_addr == 3'd4);

    AST_GPIO_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe ^ dir) & ~func) == '0);                        // R3
    AST_ALT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe ^ ALT_DIR) & func) == '0);                     // R4
    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> (($past(stat) & ~stat) == '0));            // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(~(sync ^ lvl)) & ~stat) == '0));       // R8
    AST_NMI_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat & nmie)) |=> nmi);                              // R9
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_PINS] == '0);                    // R10
endmodule

bind gpio_lvl_ctrl gpio_lvl_chk #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ALT_DIR(ALT_DIR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .func      (func_w),
    .dir       (dir_w),
    .lvl       (lvl_w),
    .stat      (stat_w),
    .nmie      (nmie_w),
    .sync      (pin_sync),
    .nmi       (nmi_o)
);

// File: tb/gpio_lvl_ctrl_tb.sv
module gpio_lvl_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [13:0] pin_in = '0;
    logic [13:0] pin_out, pin_oe;
    logic [13:0] alt_out = '0;
    logic [13:0] alt_in;
    logic        nmi_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    gpio_lvl_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .alt_out(alt_out), .alt_in(alt_in), .nmi_o(nmi_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 pin_oe", {18'd0, pin_oe}, 32'h0);
        chk("R1 pin_out", {18'd0, pin_out}, 32'h0);
        chk("R1 nmi", {31'd0, nmi_o}, 32'h0);
        bus_read(3'd0, v); chk("R1 func", v, 32'h0);
        bus_read(3'd1, v); chk("R1 dir", v, 32'h0);
        bus_read(3'd3, v); chk("R1 level", v, 32'h0);
        bus_read(3'd5, v); chk("R1 enable", v, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        bus_write(3'd1, 32'hFFFF_FFFF);
        bus_read(3'd1, v); chk("R10 dir upper bits", v, 32'h0000_3FFF);
        bus_write(3'd3, 32'h0000_2A5A);
        bus_read(3'd3, v); chk("R2 level", v, 32'h0000_2A5A);
        bus_write(3'd5, 32'hFFFF_0040);
        bus_read(3'd5, v); chk("R2 enable", v, 32'h0000_0040);
        bus_write(3'd5, 32'h0);
        bus_read(3'd6, v); chk("R2 index 6", v, 32'h0);
        bus_read(3'd7, v); chk("R2 index 7", v, 32'h0);
        bus_read(3'd0, v); chk("R2 func still zero", v, 32'h0);
    endtask

    task automatic t_gpio();
        bus_write(3'd0, 32'h0);
        bus_write(3'd1, 32'h0000_00F0);
        bus_write(3'd2, 32'h0000_1234);
        alt_out = 14'h3FFF;
        @(negedge clk);
        chk("R3 oe", {18'd0, pin_oe}, 32'h0000_00F0);
        chk("R3 out", {18'd0, pin_out}, 32'h0000_1234);
    endtask

    task automatic t_alt();
        alt_out = 14'h2A55;
        bus_write(3'd1, 32'h0);
        bus_write(3'd0, 32'h0000_3FFF);
        @(negedge clk);
        chk("R4 oe full alt", {18'd0, pin_oe}, 32'h0000_35F5);
        chk("R4 out full alt", {18'd0, pin_out}, 32'h0000_2A55);
        bus_write(3'd1, 32'h0000_3FF0);
        bus_write(3'd0, 32'h0000_000F);
        @(negedge clk);
        chk("R4 oe mixed", {18'd0, pin_oe}, 32'h0000_3FF5);
        chk("R4 out mixed", {18'd0, pin_out}, 32'h0000_1235);
        bus_write(3'd0, 32'h0);
        bus_write(3'd1, 32'h0);
    endtask

    task automatic t_sync();
        logic [31:0] v;
        @(negedge clk);
        pin_in = 14'h1555;
        @(negedge clk);
        chk("R11 one edge", {18'd0, alt_in}, 32'h0);
        @(negedge clk);
        chk("R11 two edges", {18'd0, alt_in}, 32'h0000_1555);
        bus_read(3'd2, v); chk("R5 data read", v, 32'h0000_1555);
    endtask

    task automatic t_status();
        logic [31:0] v;
        @(negedge clk);
        pin_in = '0;
        bus_write(3'd3, 32'h0000_3FFF);
        repeat (3) @(negedge clk);
        bus_write(3'd4, 32'h0000_3FFF);
        bus_read(3'd4, v); chk("R7 clear all", v, 32'h0);
        pin_in = 14'h0020;
        repeat (2) @(negedge clk);
        pin_in = '0;
        repeat (4) @(negedge clk);
        bus_read(3'd4, v); chk("R6 sticky after pulse", v, 32'h0000_0020);
        bus_write(3'd4, 32'h0000_0001);
        bus_read(3'd4, v); chk("R7 zero bits keep", v, 32'h0000_0020);
        bus_write(3'd4, 32'h0000_0020);
        bus_read(3'd4, v); chk("R7 one clears", v, 32'h0);
    endtask

    task automatic t_setwins();
        logic [31:0] v;
        @(negedge clk);
        pin_in = 14'h0008;
        repeat (4) @(negedge clk);
        bus_write(3'd4, 32'h0000_0008);
        bus_read(3'd4, v); chk("R8 set beats clear", v, 32'h0000_0008);
        pin_in = '0;
        repeat (3) @(negedge clk);
        bus_write(3'd4, 32'h0000_0008);
        bus_read(3'd4, v); chk("R8 later clear", v, 32'h0);
    endtask

    task automatic t_nmi();
        logic [31:0] v;
        bus_write(3'd5, 32'h0000_0040);
        @(negedge clk);
        pin_in = 14'h0080;
        repeat (2) @(negedge clk);
        pin_in = '0;
        repeat (4) @(negedge clk);
        chk("R9 disabled bit quiet", {31'd0, nmi_o}, 32'h0);
        bus_read(3'd4, v); chk("R9 disabled bit status", v, 32'h0000_0080);
        pin_in = 14'h0040;
        repeat (2) @(negedge clk);
        pin_in = '0;
        @(negedge clk);
        chk("R9 not yet", {31'd0, nmi_o}, 32'h0);
        @(negedge clk);
        chk("R9 raised", {31'd0, nmi_o}, 32'h1);
        bus_write(3'd4, 32'h0000_00C0);
        repeat (2) @(negedge clk);
        chk("R9 dropped", {31'd0, nmi_o}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_gpio();
        t_alt();
        t_sync();
        t_status();
        t_setwins();
        t_nmi();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule